// File: doc/BRIEF.md
# Sleep Mode Wake-Up Controller

This block holds the power mode of a small system and decides when it returns to Active. Software issues a one-cycle request strobe that carries a 3-bit target mode and a RAM-retention choice. Sleep depth increases in this order: Active, Idle, Standby, Hibernate, Backup, Off. Once asleep, the block watches only the wake sources that the current depth allows:

- Idle and Standby accept any interrupt.
- Hibernate and Backup accept only backup-domain interrupts.
- Off accepts only the external reset.

The outputs are the current mode, a set of status flags decoded from it, and a one-cycle wake pulse. Downstream logic uses these to halt the CPU, power down the main domain, stop the main clocks and keep or drop RAM contents. This block switches no power or clocks itself.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `mode` is 0 (Active), `wake` is 0, `cpu_halt` is 0, and both `main_pwr` and `ram_ret` are 1.
- R2: Mode encodings are Active=0, Idle=1, Standby=2, Hibernate=3, Backup=4, Off=5. In Active, a `req_valid` with `req_mode` 1..5 sets `mode` to that value on the next cycle. A request with `req_mode` 0 leaves Active unchanged. A request with `req_mode` 6 or 7 enters Idle (1).
- R3: In Idle or Standby, any set bit of `irq` or of `bkp_irq` returns `mode` to 0 on the next cycle.
- R4: In Hibernate or Backup, `irq` has no effect on `mode`. Any set bit of `bkp_irq` returns `mode` to 0 on the next cycle.
- R5: In Off, neither `irq` nor `bkp_irq` changes `mode`. Only `ext_rst` leaves Off.
- R6: `ext_rst` high in any mode gives `mode` 0 on the next cycle. It takes precedence over a request made in the same cycle.
- R7: `wake` is high for exactly one cycle, the first cycle in Active after leaving any sleep mode (1..5). It is low at all other times, including when `ext_rst` is applied while already Active.
- R8: A request made in any sleep mode is dropped. `mode` is unchanged unless a valid wake source is present. If a wake source is present in the same cycle, the system goes to Active, not to the requested mode.
- R9: `ram_ret` is 1 in modes 0..2. In Hibernate it equals the `req_retain` value that was sampled with the accepted request. In Backup and Off it is 0.
- R10: `cpu_halt` is 1 in every mode except 0. `main_pwr` is 1 in modes 0..2 only. `nvm_sleep` is 1 in Standby only. `clk32_only` is 1 in Hibernate and Backup only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| req_valid | input | 1 | Sleep request strobe |
| req_mode | input | 3 | Requested mode encoding |
| req_retain | input | 1 | RAM retention choice for Hibernate |
| irq | input | GEN_IRQS | General interrupt lines |
| bkp_irq | input | BKP_IRQS | Backup-domain interrupt lines |
| ext_rst | input | 1 | Synchronous external reset, active high |
| mode | output | 3 | Current mode |
| cpu_halt | output | 1 | CPU halted |
| main_pwr | output | 1 | Main logic domain powered |
| nvm_sleep | output | 1 | Non-volatile memory in sleep |
| clk32_only | output | 1 | Main clocks stopped, only the slow clock runs |
| ram_ret | output | 1 | RAM contents retained |
| wake | output | 1 | One-cycle wake pulse |

## Verification
The hardest cases to reach are those where a request and a wake source land in the same cycle while the system is asleep, and the Off state, whose only exit is the external reset. The stimulus first puts the block into each depth through the request port. It then drives stray general interrupts, stray backup interrupts and fresh requests over several cycles, some of them together with a valid wake source. This shows that only the correct source moves the mode, and that it always goes to Active. A reference model in the bench tracks mode, retention and the wake pulse every cycle and compares all outputs on each clock.

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int GEN_IRQS = 8,
  parameter int BKP_IRQS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [2:0]          req_mode,
  input  logic                req_retain,
  input  logic [GEN_IRQS-1:0] irq,
  input  logic [BKP_IRQS-1:0] bkp_irq,
  input  logic                ext_rst,
  output logic [2:0]          mode,
  output logic                cpu_halt,
  output logic                main_pwr,
  output logic                nvm_sleep,
  output logic                clk32_only,
  output logic                ram_ret,
  output logic                wake
);

  localparam logic [2:0] M_ACT = 3'd0;
  localparam logic [2:0] M_IDL = 3'd1;
  localparam logic [2:0] M_STB = 3'd2;
  localparam logic [2:0] M_HIB = 3'd3;
  localparam logic [2:0] M_BKP = 3'd4;
  localparam logic [2:0] M_OFF = 3'd5;

  logic [2:0] mode_q;
  logic       ret_q;
  logic       wake_q;
  logic       wake_src;
  logic       take_req;
  logic [2:0] req_tgt;
  logic       any_gen;
  logic       any_bkp;

  assign any_gen = |irq;
  assign any_bkp = |bkp_irq;

  always_comb begin
    if (ext_rst) wake_src = 1'b1;
    else begin
      case (mode_q)
        M_ACT:        wake_src = 1'b0;
        M_IDL, M_STB: wake_src = any_gen | any_bkp;
        M_HIB, M_BKP: wake_src = any_bkp;
        M_OFF:        wake_src = 1'b0;
        default:      wake_src = 1'b1;
      endcase
    end
  end

  assign take_req = req_valid && (mode_q == M_ACT) && !ext_rst;
  assign req_tgt  = (req_mode > M_OFF) ? M_IDL : req_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_ACT;
      ret_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= wake_src && (mode_q != M_ACT);
      if (wake_src) mode_q <= M_ACT;
      else if (take_req) begin
        mode_q <= req_tgt;
        ret_q  <= req_retain;
      end
    end
  end

  assign mode       = mode_q;
  assign wake       = wake_q;
  assign cpu_halt   = (mode_q != M_ACT);
  assign main_pwr   = (mode_q <= M_STB);
  assign nvm_sleep  = (mode_q == M_STB);
  assign clk32_only = (mode_q == M_HIB) || (mode_q == M_BKP);
  assign ram_ret    = (mode_q <= M_STB) || ((mode_q == M_HIB) && ret_q);

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wake |=> !wake); // R7
  AST_WAKE_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) wake |-> (mode == M_ACT)); // R7
  AST_EXT_RST_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) ext_rst |=> (mode == M_ACT)); // R6
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF && !ext_rst) |=> (mode == M_OFF)); // R5
  AST_BACKUP_GEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_HIB || mode == M_BKP) && bkp_irq == '0 && !ext_rst) |=> $stable(mode)); // R4
  AST_IDLE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_IDL || mode == M_STB) && (irq != '0)) |=> (mode == M_ACT)); // R3
  AST_SLEEP_REQ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_ACT && req_valid) |=> (mode == M_ACT || $stable(mode))); // R8

endmodule

// File: tb/sleep_wake_ctrl_test.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_test;
  localparam int NG = 8;
  localparam int NB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_mode = '0;
  logic req_retain = 1'b0;
  logic [NG-1:0] irq = '0;
  logic [NB-1:0] bkp_irq = '0;
  logic ext_rst = 1'b0;
  logic [2:0] mode;
  logic cpu_halt, main_pwr, nvm_sleep, clk32_only, ram_ret, wake;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit started = 0;

  always #5 clk = ~clk;

  sleep_wake_ctrl #(.GEN_IRQS(NG), .BKP_IRQS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_retain(req_retain), .irq(irq), .bkp_irq(bkp_irq), .ext_rst(ext_rst),
    .mode(mode), .cpu_halt(cpu_halt), .main_pwr(main_pwr), .nvm_sleep(nvm_sleep),
    .clk32_only(clk32_only), .ram_ret(ram_ret), .wake(wake));

  int m_mode = 0;
  bit m_ret = 0;
  bit m_wake = 0;
  bit w;

  always @(posedge clk or negedge rst_n) begin
    started <= 1;
    if (!rst_n) begin
      m_mode <= 0; m_ret <= 0; m_wake <= 0;
    end else begin
      if (ext_rst) w = 1;
      else if (m_mode == 1 || m_mode == 2) w = (irq != 0) || (bkp_irq != 0);
      else if (m_mode == 3 || m_mode == 4) w = (bkp_irq != 0);
      else w = 0;
      if (w) begin
        m_wake <= (m_mode != 0);
        m_mode <= 0;
      end else begin
        m_wake <= 0;
        if (m_mode == 0 && req_valid) begin
          m_mode <= (req_mode > 5) ? 1 : int'(req_mode);
          m_ret <= req_retain;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk(tag, "mode", int'(mode), m_mode);
    chk("R7", "wake", int'(wake), int'(m_wake));
    chk("R9", "ram_ret", int'(ram_ret), (m_mode <= 2 || (m_mode == 3 && m_ret)) ? 1 : 0);
    chk("R10", "cpu_halt", int'(cpu_halt), (m_mode != 0) ? 1 : 0);
    chk("R10", "main_pwr", int'(main_pwr), (m_mode <= 2) ? 1 : 0);
    chk("R10", "nvm_sleep", int'(nvm_sleep), (m_mode == 2) ? 1 : 0);
    chk("R10", "clk32_only", int'(clk32_only), (m_mode == 3 || m_mode == 4) ? 1 : 0);
  end

  task automatic drive(input string t, input bit v, input int md, input bit rt,
                       input int ig, input int ib, input bit xr, input int n);
    tag = t;
    req_valid = v; req_mode = 3'(md); req_retain = rt;
    irq = NG'(ig); bkp_irq = NB'(ib); ext_rst = xr;
    repeat (n) @(negedge clk);
    req_valid = 0; req_mode = 0; req_retain = 0; irq = 0; bkp_irq = 0; ext_rst = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    // R2: request Active keeps Active
    drive("R2", 1, 0, 0, 0, 0, 0, 1); idle(1);
    // R2/R3: Idle, woken by general irq
    drive("R2", 1, 1, 0, 0, 0, 0, 1); idle(2);
    drive("R3", 0, 0, 0, 8, 0, 0, 1); idle(2);
    // R8: Standby, request dropped, then backup irq wakes
    drive("R2", 1, 2, 0, 0, 0, 0, 1); idle(2);
    drive("R8", 1, 4, 1, 0, 0, 0, 2); idle(1);
    drive("R3", 0, 0, 0, 0, 2, 0, 1); idle(2);
    // R2: code 6 becomes Idle, woken by backup irq
    drive("R2", 1, 6, 0, 0, 0, 0, 1); idle(1);
    drive("R3", 0, 0, 0, 0, 1, 0, 1); idle(1);
    // R4/R9: Hibernate with retention, general irq ignored
    drive("R9", 1, 3, 1, 0, 0, 0, 1); idle(2);
    drive("R4", 0, 0, 0, 255, 0, 0, 3);
    drive("R8", 1, 1, 0, 0, 0, 0, 1); idle(1);
    drive("R4", 0, 0, 0, 0, 2, 0, 1); idle(2);
    // R6/R9: Hibernate without retention, ext reset exits
    drive("R9", 1, 3, 0, 0, 0, 0, 1); idle(2);
    drive("R6", 0, 0, 0, 0, 0, 1, 1); idle(2);
    // R4: Backup
    drive("R2", 1, 4, 1, 0, 0, 0, 1); idle(1);
    drive("R4", 0, 0, 0, 1, 0, 0, 2);
    drive("R4", 0, 0, 0, 0, 3, 0, 1); idle(2);
    // R5: Off ignores everything but ext reset
    drive("R2", 1, 5, 1, 0, 0, 0, 1); idle(1);
    drive("R5", 0, 0, 0, 255, 3, 0, 4);
    drive("R8", 1, 0, 0, 16, 1, 0, 1); idle(2);
    drive("R5", 0, 0, 0, 0, 0, 1, 1); idle(3);
    // R6/R7: ext reset with request while Active, no wake pulse
    drive("R6", 1, 3, 1, 0, 0, 1, 1); idle(2);
    // R8: code 7 gives Idle, request plus wake goes to Active
    drive("R2", 1, 7, 0, 0, 0, 0, 1); idle(1);
    drive("R8", 1, 4, 0, 1, 0, 0, 1); idle(2);
    // R1: reset in a sleep mode
    drive("R2", 1, 4, 0, 0, 0, 0, 1); idle(1);
    tag = "R1";
    rst_n = 0; idle(2); rst_n = 1; idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule